// File: doc/BRIEF.md
# Queued Signal State Machine

This block is a small protocol controller whose inputs are signal codes rather than levels. Each arriving code is written into a bounded first-in first-out queue. On each clock the controller may take the oldest queued code and look it up against the codes that its present state accepts. A hit moves the machine to its next state. It may also place a result code on a valid/ready output port. A code that does not fit the present state is thrown away.

A single local countdown timer is started and stopped by the transitions themselves. When it runs out, a dedicated expiry code is written into the same queue as every external code. The machine then handles that expiry in order, like any other signal. A late completion therefore lands in a state that accepts it silently. A completion that arrives in time produces a result.

Top module: `sigq_fsm`

## Requirements
- R1: Accepted codes are handled strictly in the order they entered the queue; the queue holds at most DEPTH entries.
- R2: At most one entry leaves the queue per clock. An entry is taken only when the queue is not empty and the output register is free, meaning out_valid is 0 or out_ready is 1.
- R3: States are encoded IDLE=0, READY=1, WAIT=2, LATE=3 on fsm_state. Input codes are START=1, GO=2, DONE=3, ABORT=4, and the internal expiry code is 7. Result codes are ACK=1, BUSY=2, FINISH=3, ABORTED=4. The transitions are:
  - IDLE+START goes to READY and emits ACK.
  - READY+GO goes to WAIT, emits BUSY and starts the timer.
  - WAIT+DONE goes to IDLE, emits FINISH and stops the timer.
  - WAIT+7 goes to LATE with no result.
  - LATE+DONE goes to IDLE with no result.
  - ABORT in READY, WAIT or LATE goes to IDLE, emits ABORTED and stops the timer.
- R4: A taken entry that has no transition in the present state is dropped. The state does not change and no result is emitted.
- R5: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_sig keeps its value. A result is emitted on the clock that takes its entry, and out_valid falls after a handshake when no new result follows.
- R6: An external code offered while the queue holds DEPTH entries, judged on the count before that clock, is not stored. It sets ovf, which stays 1 until reset.
- R7: The expiry code 7 is appended EXPIRE_CYCLES+1 clocks after the clock that started the timer. If an external code is accepted on the same clock, the expiry code goes in behind it. If there is no room, the expiry code waits until there is.
- R8: Stopping the timer cancels both the running count and any expiry not yet queued. DONE after expiry yields no FINISH.
- R9: After reset the state is IDLE, the queue is empty, out_valid and ovf are 0 and the timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Offer of an external code this clock |
| in_sig | input | 3 | External signal code |
| out_valid | output | 1 | Result code present |
| out_sig | output | 3 | Result code |
| out_ready | input | 1 | Consumer takes the result this clock |
| fsm_state | output | 2 | Present state encoding |
| ovf | output | 1 | Sticky queue overflow flag |

## Verification
The bench targets four cases:
- A completion arriving after the timer has run out. A machine that lets the expiry overtake queued codes, or that ignores it, would wrongly emit FINISH.
- A stalled output port. A design that keeps consuming under backpressure would lose results or change state early.
- Offers into a full queue, and the collision of an external offer with a pending expiry on the same clock. Wrong room arithmetic would store too much or reorder the entries.
- A long pseudo-random stretch of codes and ready patterns, compared on every clock against a behavioural queue model. This exposes off-by-one timer lengths and dropped-code handling that changes state.

// File: rtl/sigq_pkg.sv
package sigq_pkg;

    localparam int SIG_W = 3;
    typedef logic [SIG_W-1:0] sig_t;

    // external and internal input codes
    localparam sig_t SIG_START  = 3'd1;
    localparam sig_t SIG_GO     = 3'd2;
    localparam sig_t SIG_DONE   = 3'd3;
    localparam sig_t SIG_ABORT  = 3'd4;
    localparam sig_t SIG_EXPIRE = 3'd7;

    // result codes
    localparam sig_t RES_ACK     = 3'd1;
    localparam sig_t RES_BUSY    = 3'd2;
    localparam sig_t RES_FINISH  = 3'd3;
    localparam sig_t RES_ABORTED = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_WAIT  = 2'd2,
        ST_LATE  = 2'd3
    } st_t;

    typedef enum logic [1:0] {
        TA_NONE  = 2'd0,
        TA_START = 2'd1,
        TA_STOP  = 2'd2
    } tact_t;

    typedef struct packed {
        logic  hit;
        st_t   nxt;
        logic  emit;
        sig_t  res;
        tact_t tact;
    } xition_t;

    function automatic xition_t mk_hit(st_t n, logic e, sig_t r, tact_t t);
        xition_t x;
        x.hit  = 1'b1;
        x.nxt  = n;
        x.emit = e;
        x.res  = r;
        x.tact = t;
        return x;
    endfunction

    // transition table held as logic
    function automatic xition_t lookup(st_t s, sig_t g);
        xition_t x;
        x.hit  = 1'b0;
        x.nxt  = s;
        x.emit = 1'b0;
        x.res  = '0;
        x.tact = TA_NONE;
        case (s)
            ST_IDLE: begin
                if (g == SIG_START) x = mk_hit(ST_READY, 1'b1, RES_ACK, TA_NONE);
            end
            ST_READY: begin
                if (g == SIG_GO)         x = mk_hit(ST_WAIT, 1'b1, RES_BUSY, TA_START);
                else if (g == SIG_ABORT) x = mk_hit(ST_IDLE, 1'b1, RES_ABORTED, TA_STOP);
            end
            ST_WAIT: begin
                if (g == SIG_DONE)        x = mk_hit(ST_IDLE, 1'b1, RES_FINISH, TA_STOP);
                else if (g == SIG_EXPIRE) x = mk_hit(ST_LATE, 1'b0, '0, TA_NONE);
                else if (g == SIG_ABORT)  x = mk_hit(ST_IDLE, 1'b1, RES_ABORTED, TA_STOP);
            end
            default: begin
                if (g == SIG_DONE)       x = mk_hit(ST_IDLE, 1'b0, '0, TA_NONE);
                else if (g == SIG_ABORT) x = mk_hit(ST_IDLE, 1'b1, RES_ABORTED, TA_STOP);
            end
        endcase
        return x;
    endfunction

endpackage

// File: rtl/sigq_fifo.sv
module sigq_fifo
    import sigq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic a_req,
    input  sig_t a_data,
    input  logic b_req,
    input  sig_t b_data,
    input  logic rd_en,
    output logic a_acc,
    output logic b_acc,
    output logic not_empty,
    output sig_t head,
    output logic ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    sig_t          mem [DEPTH];
    logic [CW-1:0] cnt;
    logic [PW-1:0] wp, rp;
    logic [PW-1:0] wp_b;

    function automatic logic [PW-1:0] adv(logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + PW'(1);
    endfunction

    // room is judged on the count held at the start of the clock
    assign a_acc     = a_req && (cnt < FULL);
    assign b_acc     = b_req && (a_acc ? (cnt < FULL - CW'(1)) : (cnt < FULL));
    assign not_empty = (cnt != '0);
    assign head      = mem[rp];
    assign wp_b      = a_acc ? adv(wp) : wp;

    always_ff @(posedge clk) begin
        if (a_acc) mem[wp]   <= a_data;
        if (b_acc) mem[wp_b] <= b_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            wp  <= '0;
            rp  <= '0;
            ovf <= 1'b0;
        end else begin
            if (b_acc)      wp <= adv(wp_b);
            else if (a_acc) wp <= adv(wp);
            if (rd_en)      rp <= adv(rp);
            cnt <= cnt + CW'(a_acc) + CW'(b_acc) - CW'(rd_en);
            if (a_req && !a_acc) ovf <= 1'b1;
        end
    end

    // R6
    full_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (a_req && cnt == FULL) |=> ovf);

    // R2
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (cnt != '0));

endmodule

// File: rtl/sigq_timer.sv
module sigq_timer #(
    parameter int EXPIRE_CYCLES = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop,
    input  logic taken,
    output logic pend
);
    localparam int CNT_W = $clog2(EXPIRE_CYCLES + 1);

    logic [CNT_W-1:0] cnt;
    logic             active;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= 1'b0;
            pend   <= 1'b0;
        end else if (start) begin
            cnt    <= CNT_W'(EXPIRE_CYCLES);
            active <= 1'b1;
            pend   <= 1'b0;
        end else if (stop) begin
            active <= 1'b0;
            pend   <= 1'b0;
        end else begin
            if (taken) pend <= 1'b0;
            if (active) begin
                if (cnt == CNT_W'(1)) begin
                    active <= 1'b0;
                    pend   <= 1'b1;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end
        end
    end

    // R7
    expire_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(active));

    // R8
    stop_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (stop && !start) |=> (!active && !pend));

endmodule

// File: rtl/sigq_step.sv
module sigq_step
    import sigq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic not_empty,
    input  sig_t head,
    input  logic out_ready,
    output logic pop,
    output logic tmr_start,
    output logic tmr_stop,
    output st_t  state,
    output logic out_valid,
    output sig_t out_sig
);
    xition_t xt;

    assign pop       = not_empty && (!out_valid || out_ready);
    assign xt        = lookup(state, head);
    assign tmr_start = pop && xt.hit && (xt.tact == TA_START);
    assign tmr_stop  = pop && xt.hit && (xt.tact == TA_STOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            out_valid <= 1'b0;
            out_sig   <= '0;
        end else if (pop) begin
            out_valid <= xt.hit && xt.emit;
            if (xt.hit) begin
                state <= xt.nxt;
                if (xt.emit) out_sig <= xt.res;
            end
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R4
    drop_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !xt.hit) |=> $stable(state));

endmodule

// File: rtl/sigq_fsm.sv
module sigq_fsm
    import sigq_pkg::*;
#(
    parameter int DEPTH         = 4,
    parameter int EXPIRE_CYCLES = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [SIG_W-1:0] in_sig,
    output logic             out_valid,
    output logic [SIG_W-1:0] out_sig,
    input  logic             out_ready,
    output logic [1:0]       fsm_state,
    output logic             ovf
);
    logic a_acc, b_acc, not_empty, pop;
    logic tmr_start, tmr_stop, pend;
    sig_t head;
    st_t  state;

    sigq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .a_req     (in_valid),
        .a_data    (in_sig),
        .b_req     (pend),
        .b_data    (SIG_EXPIRE),
        .rd_en     (pop),
        .a_acc     (a_acc),
        .b_acc     (b_acc),
        .not_empty (not_empty),
        .head      (head),
        .ovf       (ovf)
    );

    sigq_timer #(.EXPIRE_CYCLES(EXPIRE_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (tmr_start),
        .stop  (tmr_stop),
        .taken (b_acc),
        .pend  (pend)
    );

    sigq_step u_step (
        .clk       (clk),
        .rst       (rst),
        .not_empty (not_empty),
        .head      (head),
        .out_ready (out_ready),
        .pop       (pop),
        .tmr_start (tmr_start),
        .tmr_stop  (tmr_stop),
        .state     (state),
        .out_valid (out_valid),
        .out_sig   (out_sig)
    );

    assign fsm_state = state;

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sig)));

endmodule

// File: tb/tb_sigq_fsm.sv
module tb_sigq_fsm;
    localparam int CLK_P = 10;
    localparam int DEPTH = 4;
    localparam int CYC   = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [2:0] in_sig = '0;
    logic       out_ready = 1'b1;
    logic       out_valid;
    logic [2:0] out_sig;
    logic [1:0] fsm_state;
    logic       ovf;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;
    int rec[$];

    // behavioural reference
    int mq[$];
    int m_state = 0, m_ov = 0, m_osig = 0, m_ovf = 0;
    int m_act = 0, m_cnt = 0, m_pend = 0;

    sigq_fsm #(.DEPTH(DEPTH), .EXPIRE_CYCLES(CYC)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sig(in_sig),
        .out_valid(out_valid), .out_sig(out_sig), .out_ready(out_ready),
        .fsm_state(fsm_state), .ovf(ovf)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic ref_step(input int s, input int g, output bit hit,
                            output int ns, output int em, output int rs, output int tk);
        hit = 0; ns = s; em = 0; rs = 0; tk = 0;
        if (s == 0 && g == 1)                    begin hit = 1; ns = 1; em = 1; rs = 1; end
        else if (s == 1 && g == 2)               begin hit = 1; ns = 2; em = 1; rs = 2; tk = 1; end
        else if (s == 2 && g == 3)               begin hit = 1; ns = 0; em = 1; rs = 3; tk = 2; end
        else if (s == 2 && g == 7)               begin hit = 1; ns = 3; end
        else if (s == 3 && g == 3)               begin hit = 1; ns = 0; end
        else if (s != 0 && g == 4)               begin hit = 1; ns = 0; em = 1; rs = 4; tk = 2; end
    endtask

    always @(posedge clk) begin
        int  freec, hd, ns, em, rs, tk;
        bit  ea, ta, pp, hit;
        if (rst) begin
            mq.delete();
            m_state = 0; m_ov = 0; m_osig = 0; m_ovf = 0;
            m_act = 0; m_cnt = 0; m_pend = 0;
        end else begin
            freec = DEPTH - mq.size();
            ea = in_valid && freec >= 1;
            if (in_valid && freec == 0) m_ovf = 1;
            ta = (m_pend != 0) && (freec >= 1 + int'(ea));
            pp = (mq.size() > 0) && (m_ov == 0 || out_ready);
            tk = 0;
            if (pp) begin
                hd = mq.pop_front();
                ref_step(m_state, hd, hit, ns, em, rs, tk);
                if (hit) begin
                    m_state = ns;
                    m_ov = em;
                    if (em != 0) m_osig = rs;
                end else begin
                    m_ov = 0;
                end
            end else if (out_ready) begin
                m_ov = 0;
            end
            if (tk == 1) begin
                m_cnt = CYC; m_act = 1; m_pend = 0;
            end else if (tk == 2) begin
                m_act = 0; m_pend = 0;
            end else begin
                if (ta) m_pend = 0;
                if (m_act != 0) begin
                    if (m_cnt == 1) begin m_act = 0; m_pend = 1; end
                    else m_cnt = m_cnt - 1;
                end
            end
            if (ea) mq.push_back(int'(in_sig));
            if (ta) mq.push_back(7);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // every-clock comparison and handshake log, a quarter period after the falling edge
    always @(negedge clk) begin
        #(CLK_P/4);
        if (!rst) begin
            chk("R3 state vs model", int'(fsm_state), m_state);
            chk("R5 out_valid vs model", int'(out_valid), m_ov);
            if (m_ov != 0) chk("R3 out_sig vs model", int'(out_sig), m_osig);
            chk("R6 ovf vs model", int'(ovf), m_ovf);
            if (out_valid && out_ready) rec.push_back(int'(out_sig));
        end
    end

    task automatic step(input bit v, input int s, input bit r);
        in_valid = v; in_sig = 3'(s); out_ready = r;
        @(negedge clk);
    endtask

    task automatic idle(input int n, input bit r);
        for (int i = 0; i < n; i++) step(0, 0, r);
    endtask

    task automatic send(input int s);
        step(1, s, 1);
    endtask

    task automatic wrap_up();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        wrap_up();
    end

    initial begin
        int lf;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9 reset state
        chk("R9 state", int'(fsm_state), 0);
        chk("R9 out_valid", int'(out_valid), 0);
        chk("R9 ovf", int'(ovf), 0);

        // R3 first transition
        send(1); idle(1, 1);
        chk("R3 state READY", int'(fsm_state), 1);
        chk("R3 ACK valid", int'(out_valid), 1);
        chk("R3 ACK code", int'(out_sig), 1);

        // R4 DONE is not accepted in READY
        idle(2, 1);
        send(3); idle(2, 1);
        chk("R4 state kept", int'(fsm_state), 1);
        chk("R4 no result", int'(out_valid), 0);

        // R7 expiry reaches WAIT and moves to LATE
        send(2); idle(CYC + 6, 1);
        chk("R7 state LATE", int'(fsm_state), 3);
        rec.delete();
        send(3); idle(3, 1);
        chk("R8 state IDLE", int'(fsm_state), 0);
        chk("R8 no FINISH after expiry", rec.size(), 0);

        // R1 order of handling
        rec.delete();
        send(1); send(2); send(3); idle(5, 1);
        chk("R1 result count", rec.size(), 3);
        if (rec.size() == 3) begin
            chk("R1 first", rec[0], 1);
            chk("R1 second", rec[1], 2);
            chk("R1 third", rec[2], 3);
        end
        // R8 the stopped timer queues nothing
        idle(CYC + 4, 1);
        chk("R8 still IDLE", int'(fsm_state), 0);

        // R2 and R5 under backpressure
        step(1, 1, 0); step(1, 2, 0); idle(5, 0);
        chk("R5 held valid", int'(out_valid), 1);
        chk("R5 held code", int'(out_sig), 1);
        chk("R2 no take while stalled", int'(fsm_state), 1);
        // R6 fill past the limit
        for (int i = 0; i < DEPTH + 1; i++) step(1, 3, 0);
        idle(1, 0);
        chk("R6 overflow flagged", int'(ovf), 1);
        idle(40, 1);
        chk("R6 sticky", int'(ovf), 1);

        // R3 ABORT out of WAIT
        rec.delete();
        send(1); send(2); idle(3, 1); send(4); idle(2, 1);
        chk("R3 abort state", int'(fsm_state), 0);
        chk("R3 abort code", (rec.size() > 0) ? rec[rec.size()-1] : -1, 4);
        idle(CYC + 4, 1);
        chk("R8 abort cancels timer", int'(fsm_state), 0);

        // pseudo-random stretch, compared each clock against the model
        lf = 32'h1ace5eed;
        for (int i = 0; i < 600; i++) begin
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >>> 17);
            lf = lf ^ (lf << 5);
            step(lf[3] | lf[9], (lf[6:4] % 5) + 1, lf[12] | lf[15]);
        end
        idle(40, 1);

        wrap_up();
    end

endmodule